// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block buffers 18-bit words between two unrelated clock domains. A producer writes on its own clock with an active-low write enable. A consumer pulls words on a second clock with an active-low read enable into a registered output. Both pointers cross between the domains as Gray codes through two-flop synchronisers. The block drives five active-low status flags: empty, full, almost-empty, almost-full and half-full.

The almost-empty threshold `ae_lvl` (n) and the almost-full threshold `af_lvl` (m) arrive as quasi-static inputs from a separate offset register. For the default 1024-word depth, that register's reset values are n = 127 and m = 127. A shared `ld_n` input, held LOW while that offset register is being accessed, suspends both FIFO ports. The output register never falls through: every word, including the first one written into an empty FIFO, must be requested with a read.

Top module: `dc_fifo18`

## Requirements
- R1: While `rst_n` is LOW, both pointers return to location zero, `rd_data` is all zeros, `full_n`, `afull_n` and `hfull_n` are HIGH, and `empty_n` and `aempty_n` are LOW.
- R2: A word is stored on a rising `wr_clk` edge only when `wr_en_n` is LOW, `ld_n` is HIGH and `full_n` is HIGH; a write attempted while full or while `ld_n` is LOW changes no state.
- R3: A read on a rising `rd_clk` edge with `rd_en_n` LOW, `ld_n` HIGH and `empty_n` HIGH loads the oldest stored word into `rd_data`; otherwise `rd_data` holds, including while empty.
- R4: A word written into an empty FIFO does not appear on `rd_data` until a read is requested after `empty_n` goes HIGH.
- R5: `empty_n` is LOW exactly when the read domain sees zero words, and `full_n` is LOW exactly when the write domain sees D words (D = 2^AW).
- R6: `aempty_n` is LOW when the read-domain occupancy is n or fewer words.
- R7: `afull_n` is LOW when the write-domain occupancy is D−m or more words.
- R8: `hfull_n` is LOW when the write-domain occupancy exceeds D/2, and it returns HIGH at D/2 or fewer.
- R9: Under concurrent traffic on unrelated clocks, words leave in the order they were written, with no loss or duplication.
- R10: A read attempted while `ld_n` is LOW changes neither `rd_data` nor the occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write clock |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | DW | Word to store |
| ld_n | input | 1 | HIGH enables FIFO access; LOW suspends both ports |
| ae_lvl | input | AW | Almost-empty threshold n |
| af_lvl | input | AW | Almost-full threshold m |
| full_n | output | 1 | LOW when full (write domain) |
| afull_n | output | 1 | LOW when almost full (write domain) |
| hfull_n | output | 1 | LOW when more than half full (write domain) |
| rd_clk | input | 1 | Read clock |
| rd_en_n | input | 1 | Active-low read request |
| rd_data | output | DW | Registered output word |
| empty_n | output | 1 | LOW when empty (read domain) |
| aempty_n | output | 1 | LOW when almost empty (read domain) |

## Verification
A data word and every flag of the operating domain settle right after the clock edge that performs the operation, so the bench checks them at the next falling edge of that clock. A flag driven from the opposite domain waits for the pointer to pass two synchroniser flops, which takes at most three edges of the observing clock. After each single write or read, the bench therefore waits four falling edges of each clock before it compares the five flags with the occupancy that its queue model expects. In the concurrent phase, data is compared one read-clock falling edge after each issued read, and the bench acts on flags as they are sampled, never on counts derived from them.

// File: rtl/dc_fifo18.sv
module dc_fifo18 #(
  parameter int DW = 18,
  parameter int AW = 10
) (
  input  logic          rst_n,
  input  logic          wr_clk,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic          ld_n,
  input  logic [AW-1:0] ae_lvl,
  input  logic [AW-1:0] af_lvl,
  output logic          full_n,
  output logic          afull_n,
  output logic          hfull_n,
  input  logic          rd_clk,
  input  logic          rd_en_n,
  output logic [DW-1:0] rd_data,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULLCNT = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALFCNT = (AW+1)'(DEPTH / 2);

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] from_gray(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  logic [AW:0] wbin, wgray, rg_s1, rg_s2, rbin_w, wcnt;
  logic [AW:0] rbin, rgray, wg_s1, wg_s2, wbin_r, rcnt;
  logic wr_go, rd_go;

  // write domain
  assign wr_go = !wr_en_n && ld_n && full_n;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_go) begin
      wbin  <= wbin + 1'b1;
      wgray <= to_gray(wbin + 1'b1);
    end

  always_ff @(posedge wr_clk)
    if (wr_go) mem[wbin[AW-1:0]] <= wr_data;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) {rg_s2, rg_s1} <= '0;
    else        {rg_s2, rg_s1} <= {rg_s1, rgray};

  assign rbin_w  = from_gray(rg_s2);
  assign wcnt    = wbin - rbin_w;
  assign full_n  = (wgray != {~rg_s2[AW:AW-1], rg_s2[AW-2:0]});
  assign afull_n = !(wcnt >= FULLCNT - {1'b0, af_lvl});
  assign hfull_n = !(wcnt > HALFCNT);

  // read domain
  assign rd_go = !rd_en_n && ld_n && empty_n;

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      rd_data <= '0;
    end else if (rd_go) begin
      rbin    <= rbin + 1'b1;
      rgray   <= to_gray(rbin + 1'b1);
      rd_data <= mem[rbin[AW-1:0]];
    end

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) {wg_s2, wg_s1} <= '0;
    else        {wg_s2, wg_s1} <= {wg_s1, wgray};

  assign wbin_r   = from_gray(wg_s2);
  assign rcnt     = wbin_r - rbin;
  assign empty_n  = (rgray != wg_s2);
  assign aempty_n = !(rcnt <= {1'b0, ae_lvl});
endmodule

module dc_fifo18_chk #(
  parameter int DW = 18,
  parameter int AW = 10
) (
  input logic          rst_n,
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_en_n,
  input logic          rd_en_n,
  input logic          ld_n,
  input logic          full_n,
  input logic          afull_n,
  input logic          hfull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic [DW-1:0] rd_data,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin
);
  // R1
  reset_state_chk: assert property (@(posedge rd_clk)
    !rst_n |-> (rd_data == '0) && !empty_n && !aempty_n);

  // R2
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> $stable(wbin));

  // R2
  wr_load_gate_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !ld_n |=> $stable(wbin));

  // R3
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> $stable(rbin) && $stable(rd_data));

  // R3
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_en_n |=> $stable(rd_data));

  // R10
  rd_load_gate_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !ld_n |=> $stable(rbin) && $stable(rd_data));

  // R8
  full_implies_half_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !afull_n && !hfull_n);

  // R6
  empty_implies_ae_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
endmodule

bind dc_fifo18 dc_fifo18_chk #(.DW(DW), .AW(AW)) u_chk (
  .rst_n(rst_n), .wr_clk(wr_clk), .rd_clk(rd_clk),
  .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .ld_n(ld_n),
  .full_n(full_n), .afull_n(afull_n), .hfull_n(hfull_n),
  .empty_n(empty_n), .aempty_n(aempty_n), .rd_data(rd_data),
  .wbin(wbin), .rbin(rbin)
);

// File: tb/dc_fifo18_bench.sv
module dc_fifo18_bench;
  localparam int DW = 18;
  localparam int AW = 4;
  localparam int D  = 1 << AW;

  logic          rst_n = 1'b0;
  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_en_n = 1'b1, rd_en_n = 1'b1, ld_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] ae_lvl = 4'd3, af_lvl = 4'd4;
  logic          full_n, afull_n, hfull_n, empty_n, aempty_n;
  logic [DW-1:0] rd_data;

  int checks = 0, fails = 0;
  logic [DW-1:0] q[$];

  always #4   wr_clk = ~wr_clk;
  always #5.5 rd_clk = ~rd_clk;

  dc_fifo18 #(.DW(DW), .AW(AW)) u_dc_fifo18 (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .ld_n(ld_n), .ae_lvl(ae_lvl), .af_lvl(af_lvl),
    .full_n(full_n), .afull_n(afull_n), .hfull_n(hfull_n),
    .rd_clk(rd_clk), .rd_en_n(rd_en_n), .rd_data(rd_data),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_flags(input int c, input string ctx);
    check(empty_n  == (c != 0),                      {"R5 empty ", ctx}, empty_n,  c != 0);
    check(full_n   == (c != D),                      {"R5 full ", ctx},  full_n,   c != D);
    check(aempty_n == !(c <= int'(ae_lvl)),          {"R6 ", ctx},       aempty_n, !(c <= int'(ae_lvl)));
    check(afull_n  == !(c >= D - int'(af_lvl)),      {"R7 ", ctx},       afull_n,  !(c >= D - int'(af_lvl)));
    check(hfull_n  == !(c > D/2),                    {"R8 ", ctx},       hfull_n,  !(c > D/2));
  endtask

  task automatic settle();
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en_n = 1'b0;
    wr_data = d;
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic pop();
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    @(negedge rd_clk);
    rd_en_n = 1'b1;
  endtask

  task automatic fill_and_drain(input string ctx);
    logic [DW-1:0] e;
    for (int k = 1; k <= D; k++) begin
      e = DW'(k * 37 + 5 + ae_lvl);
      push(e);
      q.push_back(e);
      settle();
      chk_flags(k, ctx);
    end
    push(18'h3ABCD);
    settle();
    chk_flags(D, "R2 write ignored when full");
    for (int k = D - 1; k >= 0; k--) begin
      pop();
      e = q.pop_front();
      check(rd_data == e, "R3 read order", int'(rd_data), int'(e));
      settle();
      chk_flags(k, ctx);
    end
    e = rd_data;
    pop();
    check(rd_data == e, "R3 read ignored when empty", int'(rd_data), int'(e));
    settle();
    chk_flags(0, "R3 empty after ignored read");
  endtask

  task automatic run_all();
    logic [DW-1:0] e;
    repeat (5) @(negedge wr_clk);
    // R1 reset state
    check(rd_data == '0, "R1 rd_data", int'(rd_data), 0);
    chk_flags(0, "R1 reset");
    rst_n = 1'b1;
    settle();

    // R4 no fall-through
    push(18'h00155);
    q.push_back(18'h00155);
    settle();
    check(rd_data == '0, "R4 no fall-through", int'(rd_data), 0);
    chk_flags(1, "R4 one word");
    pop();
    e = q.pop_front();
    check(rd_data == e, "R4 first word after read", int'(rd_data), int'(e));
    settle();

    fill_and_drain("sweep n=3 m=4");

    ae_lvl = 4'd7;
    af_lvl = 4'd2;
    settle();
    chk_flags(0, "thresholds n=7 m=2");

    // R2 write ignored with ld_n low
    ld_n = 1'b0;
    push(18'h2AAAA);
    settle();
    chk_flags(0, "R2 write ignored while ld_n low");
    ld_n = 1'b1;

    fill_and_drain("sweep n=7 m=2");

    ae_lvl = 4'd0;
    af_lvl = 4'd8;
    for (int k = 1; k <= 5; k++) begin
      e = DW'(k * 1001);
      push(e);
      q.push_back(e);
    end
    settle();
    chk_flags(5, "n=0 m=8 partial");

    // R10 read ignored with ld_n low
    e = rd_data;
    ld_n = 1'b0;
    pop();
    check(rd_data == e, "R10 rd_data held while ld_n low", int'(rd_data), int'(e));
    settle();
    chk_flags(5, "R10 occupancy kept");
    ld_n = 1'b1;
    while (q.size() > 0) begin
      pop();
      e = q.pop_front();
      check(rd_data == e, "R3 drain order", int'(rd_data), int'(e));
    end
    settle();
    chk_flags(0, "drained");

    // R9 concurrent traffic
    ae_lvl = 4'd3;
    af_lvl = 4'd4;
    fork
      begin
        int sent = 0, t = 0;
        while (sent < 300) begin
          @(negedge wr_clk);
          t++;
          if (full_n && (t % 5 != 3)) begin
            wr_en_n = 1'b0;
            wr_data = DW'(sent * 613 + 11);
            q.push_back(DW'(sent * 613 + 11));
            sent++;
          end else begin
            wr_en_n = 1'b1;
          end
        end
        @(negedge wr_clk);
        wr_en_n = 1'b1;
      end
      begin
        int got = 0, t = 0;
        bit pend = 1'b0;
        logic [DW-1:0] exp_d = '0;
        while (got < 300 || pend) begin
          @(negedge rd_clk);
          t++;
          if (pend) begin
            check(rd_data == exp_d, "R9 concurrent order", int'(rd_data), int'(exp_d));
            pend = 1'b0;
          end
          if (got < 300 && empty_n && (t % 7 < 5)) begin
            rd_en_n = 1'b0;
            exp_d = q.pop_front();
            pend = 1'b1;
            got++;
          end else begin
            rd_en_n = 1'b1;
          end
        end
        rd_en_n = 1'b1;
      end
    join
    settle();
    chk_flags(0, "R9 empty after traffic");
  endtask

  initial begin
    fork
      run_all();
      begin
        #1_000_000;
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule